// File: doc/BRIEF.md
# Auxiliary Register Address Unit

This unit keeps eight 16-bit auxiliary registers and a 3-bit pointer that marks one of them as current. The current register is presented on a registered address output for indirect data accesses. Each indirect access may post-modify the current register through a dedicated 16-bit arithmetic unit. The modification can add or subtract one, or add or subtract the index held in register 0. The index forms come in an ordinary version and a reversed-carry version. In the reversed-carry version the carry runs from the most significant bit down toward bit 0, which steps through bit-reversed addresses as FFT buffers need.

The registers also act as plain temporary storage. Any register can be written through a write port and read through a registered read port. The pointer can be reloaded in the same cycle as an access. In that case the access still modifies the register the old pointer selected. Instruction decoding and the data memory sit outside this block.

Top module: `aux_addr_unit`

## Requirements
- R1: Synchronous active-high reset clears every register, the pointer, `addr_out` and `rd_data` to zero.
- R2: When `wr_en` is high, register `wr_sel` takes `wr_data` at the clock edge. `rd_data` shows, one cycle later, the value register `rd_sel` held before that edge.
- R3: When `ptr_ld` is high, `cur_ptr` takes `ptr_val` at the edge. From the next cycle `addr_out` shows the newly selected register.
- R4: `addr_out` always equals the current register. During an access cycle it shows the value before modification, and the modified value appears from the next cycle.
- R5: `mod_sel` 1 adds one and `mod_sel` 2 subtracts one from the current register, wrapping modulo 2^16 without a flag.
- R6: `mod_sel` 3 adds register 0 and `mod_sel` 4 subtracts register 0 from the current register, modulo 2^16. The value of register 0 used is its value before the edge.
- R7: `mod_sel` 5 adds register 0 and `mod_sel` 6 subtracts register 0 with the carry or borrow propagating from bit 15 toward bit 0.
- R8: With `ind_acc` high, `mod_sel` 0 and 7 leave the register unchanged. With `ind_acc` low, no register is modified whatever `mod_sel` holds.
- R9: An access together with a pointer load modifies the register selected by the old pointer.
- R10: A direct write to the register being modified in the same cycle wins over the modification.
- R11: A direct write to a different register in an access cycle takes effect alongside the modification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register written |
| wr_data | input | 16 | Write data |
| rd_sel | input | 3 | Register read |
| rd_data | output | 16 | Registered read data |
| ptr_ld | input | 1 | Load the pointer |
| ptr_val | input | 3 | New pointer value |
| ind_acc | input | 1 | Indirect access strobe |
| mod_sel | input | 3 | Post-modify code: 0 none, 1 +1, 2 -1, 3 +index, 4 -index, 5 +index reversed, 6 -index reversed, 7 none |
| addr_out | output | 16 | Current register, used as data address |
| cur_ptr | output | 3 | Current pointer |

## Verification
The hard cases are cycles where a direct register write and a post-modification land together. In one kind they hit the same register and the write must win. In the other they hit different registers and both must land. A pointer reload can also coincide with an access, which must modify the old register. Directed steps set up each of these collisions deliberately. A long random run then biases `wr_sel` toward the current pointer so that such collisions recur. A behavioural model in the bench applies the modification first and the write second, computes reversed-carry sums bit by bit from the top, and is compared with `addr_out`, `cur_ptr` and `rd_data` every cycle.

// File: rtl/aru_pkg.sv
package aru_pkg;
  typedef enum logic [2:0] {
    MOD_NONE    = 3'd0,
    MOD_INC     = 3'd1,
    MOD_DEC     = 3'd2,
    MOD_ADD_IDX = 3'd3,
    MOD_SUB_IDX = 3'd4,
    MOD_ADD_REV = 3'd5,
    MOD_SUB_REV = 3'd6,
    MOD_RSVD    = 3'd7
  } mod_e;
endpackage

// File: rtl/aru_bitrev.sv
module aru_bitrev #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/aru_alu.sv
module aru_alu
  import aru_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          acc,
  input  logic [2:0]    code,
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] idx,
  output logic          mod_en,
  output logic [DW-1:0] res
);
  mod_e          op;
  logic [DW-1:0] cur_r, idx_r, sum_r, rev_res;

  assign op = mod_e'(code);

  aru_bitrev #(.W(DW)) u_rev_cur (.din(cur),   .dout(cur_r));
  aru_bitrev #(.W(DW)) u_rev_idx (.din(idx),   .dout(idx_r));
  aru_bitrev #(.W(DW)) u_rev_res (.din(sum_r), .dout(rev_res));

  // Reversed-carry arithmetic: mirror, add or subtract, mirror back.
  assign sum_r = (op == MOD_SUB_REV) ? (cur_r - idx_r) : (cur_r + idx_r);

  always_comb begin
    mod_en = 1'b0;
    res    = cur;
    if (acc) begin
      unique case (op)
        MOD_INC:     begin mod_en = 1'b1; res = cur + {{(DW-1){1'b0}}, 1'b1}; end
        MOD_DEC:     begin mod_en = 1'b1; res = cur - {{(DW-1){1'b0}}, 1'b1}; end
        MOD_ADD_IDX: begin mod_en = 1'b1; res = cur + idx; end
        MOD_SUB_IDX: begin mod_en = 1'b1; res = cur - idx; end
        MOD_ADD_REV,
        MOD_SUB_REV: begin mod_en = 1'b1; res = rev_res; end
        default:     begin mod_en = 1'b0; res = cur; end
      endcase
    end
  end
endmodule

// File: rtl/aru_regfile.sv
module aru_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int PW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          mod_en,
  input  logic [PW-1:0] mod_tgt,
  input  logic [DW-1:0] mod_data,
  output logic [DW-1:0] q [NREG],
  output logic [DW-1:0] d [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    // Direct write is applied last, so it wins over a modification.
    assign d[g] = (wr_en && wr_sel == PW'(g)) ? wr_data :
                  (mod_en && mod_tgt == PW'(g)) ? mod_data : q[g];

    always_ff @(posedge clk) begin
      if (rst) q[g] <= '0;
      else     q[g] <= d[g];
    end
  end
endmodule

// File: rtl/aux_addr_unit.sv
module aux_addr_unit #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int PW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          ptr_ld,
  input  logic [PW-1:0] ptr_val,
  input  logic          ind_acc,
  input  logic [2:0]    mod_sel,
  output logic [DW-1:0] addr_out,
  output logic [PW-1:0] cur_ptr
);
  logic [DW-1:0] q [NREG];
  logic [DW-1:0] d [NREG];
  logic          mod_en;
  logic [DW-1:0] mod_res;
  logic [PW-1:0] ptr_q, ptr_n;
  logic [DW-1:0] addr_q, rd_q;

  aru_alu #(.DW(DW)) u_alu (
    .acc    (ind_acc),
    .code   (mod_sel),
    .cur    (q[ptr_q]),
    .idx    (q[0]),
    .mod_en (mod_en),
    .res    (mod_res)
  );

  aru_regfile #(.DW(DW), .NREG(NREG), .PW(PW)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .mod_en   (mod_en),
    .mod_tgt  (ptr_q),
    .mod_data (mod_res),
    .q        (q),
    .d        (d)
  );

  assign ptr_n = ptr_ld ? ptr_val : ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      addr_q <= '0;
      rd_q   <= '0;
    end else begin
      ptr_q  <= ptr_n;
      addr_q <= d[ptr_n];
      rd_q   <= q[rd_sel];
    end
  end

  assign addr_out = addr_q;
  assign cur_ptr  = ptr_q;
  assign rd_data  = rd_q;
endmodule

// File: rtl/aru_checker.sv
module aru_checker #(
  parameter int DW = 16,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [PW-1:0] wr_sel,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic          ptr_ld,
  input logic [PW-1:0] ptr_val,
  input logic          ind_acc,
  input logic [2:0]    mod_sel,
  input logic [DW-1:0] addr_out,
  input logic [PW-1:0] cur_ptr
);
  logic hit_cur;
  assign hit_cur = wr_en && (wr_sel == cur_ptr);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && cur_ptr == '0 && rd_data == '0)); // R1

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    ptr_ld |=> cur_ptr == $past(ptr_val)); // R3

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ptr_ld |=> $stable(cur_ptr)); // R3

  AST_POST_INC: assert property (@(posedge clk) disable iff (rst)
    (ind_acc && mod_sel == 3'd1 && !ptr_ld && !hit_cur)
    |=> addr_out == DW'($past(addr_out) + 1'b1)); // R5

  AST_POST_DEC: assert property (@(posedge clk) disable iff (rst)
    (ind_acc && mod_sel == 3'd2 && !ptr_ld && !hit_cur)
    |=> addr_out == DW'($past(addr_out) - 1'b1)); // R5

  AST_NO_MODIFY: assert property (@(posedge clk) disable iff (rst)
    ((!ind_acc || mod_sel == 3'd0 || mod_sel == 3'd7) && !ptr_ld && !hit_cur)
    |=> $stable(addr_out)); // R8

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (hit_cur && !ptr_ld) |=> addr_out == $past(wr_data)); // R10
endmodule

bind aux_addr_unit aru_checker #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_data(rd_data), .ptr_ld(ptr_ld), .ptr_val(ptr_val), .ind_acc(ind_acc),
  .mod_sel(mod_sel), .addr_out(addr_out), .cur_ptr(cur_ptr)
);

// File: tb/aux_addr_unit_tb.sv
module aux_addr_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        ptr_ld = 1'b0;
  logic [2:0]  ptr_val = '0;
  logic        ind_acc = 1'b0;
  logic [2:0]  mod_sel = '0;
  logic [15:0] addr_out;
  logic [2:0]  cur_ptr;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [15:0] m [8];
  int          mptr = 0;
  logic [15:0] mrd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_addr_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
    .ind_acc(ind_acc), .mod_sel(mod_sel), .addr_out(addr_out), .cur_ptr(cur_ptr)
  );

  function automatic logic [15:0] rev_add(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] r = '0;
    int c = 0;
    for (int i = 15; i >= 0; i--) begin
      int s = int'(a[i]) + int'(b[i]) + c;
      r[i] = s[0];
      c = s / 2;
    end
    return r;
  endfunction

  function automatic logic [15:0] rev_sub(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] r = '0;
    int bw = 0;
    for (int i = 15; i >= 0; i--) begin
      int s = int'(a[i]) - int'(b[i]) - bw;
      bw = (s < 0) ? 1 : 0;
      r[i] = s[0];
    end
    return r;
  endfunction

  task automatic model_step();
    logic [15:0] nv;
    if (rst) begin
      for (int i = 0; i < 8; i++) m[i] = '0;
      mptr = 0;
      mrd = '0;
    end else begin
      mrd = m[rd_sel];
      nv = m[mptr];
      if (ind_acc) begin
        case (mod_sel)
          3'd1: nv = m[mptr] + 16'd1;
          3'd2: nv = m[mptr] - 16'd1;
          3'd3: nv = m[mptr] + m[0];
          3'd4: nv = m[mptr] - m[0];
          3'd5: nv = rev_add(m[mptr], m[0]);
          3'd6: nv = rev_sub(m[mptr], m[0]);
          default: nv = m[mptr];
        endcase
      end
      m[mptr] = nv;
      if (wr_en) m[wr_sel] = wr_data;
      if (ptr_ld) mptr = int'(ptr_val);
    end
  endtask

  task automatic compare(input string tag);
    n_vec++;
    if (addr_out !== m[mptr] || cur_ptr !== 3'(mptr) || rd_data !== mrd) begin
      n_bad++;
      $display("FAIL %s: addr=%h ptr=%0d rd=%h expected addr=%h ptr=%0d rd=%h",
               tag, addr_out, cur_ptr, rd_data, m[mptr], mptr, mrd);
    end
  endtask

  // Drive one cycle's inputs (at negedge), update model at posedge, compare at next negedge.
  task automatic cyc(input logic we, input logic [2:0] ws, input logic [15:0] wd,
                     input logic [2:0] rs, input logic pl, input logic [2:0] pv,
                     input logic ia, input logic [2:0] ms, input string tag);
    wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
    ptr_ld = pl; ptr_val = pv; ind_acc = ia; mod_sel = ms;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] v, input string tag);
    cyc(1'b1, s, v, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, tag);
  endtask

  task automatic acc(input logic [2:0] ms, input string tag);
    cyc(1'b0, 3'd0, 16'd0, 3'd0, 1'b0, 3'd0, 1'b1, ms, tag);
  endtask

  task automatic ld(input logic [2:0] p, input string tag);
    cyc(1'b0, 3'd0, 16'd0, 3'd0, 1'b1, p, 1'b0, 3'd0, tag);
  endtask

  task automatic rd(input logic [2:0] s, input string tag);
    cyc(1'b0, 3'd0, 16'd0, s, 1'b0, 3'd0, 1'b0, 3'd0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    cyc(1'b0, 3'd0, 16'd0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, "R1");
    cyc(1'b0, 3'd0, 16'd0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, "R1");
    rst = 1'b0;

    // R2: write every register, then read each back
    for (int i = 0; i < 8; i++) wr(3'(i), 16'h1100 + 16'(i * 16'h0111), "R2");
    for (int i = 0; i < 8; i++) rd(3'(i), "R2");
    // R2 read-before-write in the same cycle
    cyc(1'b1, 3'd4, 16'hBEEF, 3'd4, 1'b0, 3'd0, 1'b0, 3'd0, "R2");
    rd(3'd4, "R2");

    // R3: pointer load
    ld(3'd5, "R3");
    ld(3'd2, "R3");

    // R5: wrap on increment and decrement
    ld(3'd5, "R5");
    wr(3'd5, 16'hFFFF, "R5");
    acc(3'd1, "R5");
    acc(3'd2, "R5");
    acc(3'd2, "R5");

    // R6: index add/subtract, including on register 0 itself
    wr(3'd0, 16'h0010, "R6");
    acc(3'd3, "R6");
    acc(3'd4, "R6");
    acc(3'd4, "R6");
    ld(3'd0, "R6");
    acc(3'd3, "R6");

    // R7: reversed-carry walk through a 16-point buffer
    wr(3'd0, 16'h0008, "R7");
    wr(3'd3, 16'h0000, "R7");
    ld(3'd3, "R7");
    for (int i = 0; i < 18; i++) acc(3'd5, "R7");
    for (int i = 0; i < 5; i++) acc(3'd6, "R7");
    wr(3'd0, 16'h8421, "R7");
    for (int i = 0; i < 4; i++) acc(3'd5, "R7");
    for (int i = 0; i < 4; i++) acc(3'd6, "R7");

    // R8: null codes and strobe low
    acc(3'd0, "R8");
    acc(3'd7, "R8");
    cyc(1'b0, 3'd0, 16'd0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd1, "R8");
    cyc(1'b0, 3'd0, 16'd0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd5, "R8");

    // R9: pointer reload in an access cycle modifies the old register
    wr(3'd6, 16'h0100, "R9");
    ld(3'd6, "R9");
    cyc(1'b0, 3'd0, 16'd0, 3'd6, 1'b1, 3'd1, 1'b1, 3'd1, "R9");
    rd(3'd6, "R9");
    rd(3'd6, "R9");

    // R10: direct write to the register being modified wins
    cyc(1'b1, 3'd1, 16'h5A5A, 3'd0, 1'b0, 3'd0, 1'b1, 3'd3, "R10");
    cyc(1'b1, 3'd1, 16'h0001, 3'd0, 1'b0, 3'd0, 1'b1, 3'd2, "R10");

    // R11: write to another register alongside a modification
    cyc(1'b1, 3'd7, 16'h7777, 3'd0, 1'b0, 3'd0, 1'b1, 3'd1, "R11");
    rd(3'd7, "R11");
    rd(3'd1, "R11");
    cyc(1'b1, 3'd0, 16'h0003, 3'd0, 1'b0, 3'd0, 1'b1, 3'd3, "R11");

    // R4: random traffic, writes biased toward the current register
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] ws = ($urandom_range(0, 2) == 0) ? 3'(mptr) : 3'($urandom_range(0, 7));
      cyc(1'($urandom_range(0, 3) == 0), ws, 16'($urandom),
          3'($urandom_range(0, 7)), 1'($urandom_range(0, 4) == 0),
          3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
          3'($urandom_range(0, 7)), "R4");
    end

    rst = 1'b1;
    cyc(1'b0, 3'd0, 16'd0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, "R1");
    rst = 1'b0;
    rd(3'd3, "R1");
    finish_run();
  end
endmodule